// File: doc/BRIEF.md
# Quiescence handshake responder

This block answers a four-phase low-power quiescence handshake on behalf of one processor. An external power controller lowers an active-low request, which arrives with no timing relation to the block clock. The block passes it through a flip-flop synchroniser, and then either grants entry to retention by lowering an active-low accept output or refuses it by raising an active-high deny output. The answer stays in place until the controller lets the request go high again. After that the block drops its answer, leaves the quiescent state if it was in it, and goes back to running.

Three plain status pins describe the processor: WFI standby, WFE standby, and a pending wake-up reason. A grant is given only when the processor is in WFI standby with no wake-up pending at the moment the synchronised request is first seen low. Any other case is refused. A separate registered activity hint is not part of the strict handshake. Outside quiescence it is low while the processor sits in either standby state, to signal a retention opportunity. While quiescent it goes high to ask the controller to leave quiescence, and the controller may ignore it. Each processor has its own instance with its own set of pins.

Top module: `qhs_responder`

## Requirements
- R1: After reset, accept_n_o is 1, deny_o is 0 and active_o is 1.
- R2: The request passes two synchroniser flip-flops. After req_n_i goes low, accept_n_o and deny_o keep their idle values (1 and 0) through the first two rising edges and change on the third.
- R3: If wfi_i is 1 and wake_i is 0 when the synchronised request is first seen low, the block grants: accept_n_o goes to 0, deny_o stays 0, and the block is quiescent.
- R4: In every other case the block refuses: deny_o goes to 1 and accept_n_o stays 1. This covers wfi_i at 0 (WFE standby alone, or no standby) and wfi_i at 1 with wake_i at 1.
- R5: A granted accept or a refusal is held for as long as the synchronised request stays low, whatever wfi_i, wfe_i and wake_i do in that time.
- R6: After req_n_i returns high, the asserted answer is dropped on the third rising edge (two synchroniser edges plus one), and the block is back in the run state, ready for a new request.
- R7: accept_n_o at 0 and deny_o at 1 never occur in the same cycle.
- R8: Outside quiescence, active_o is registered one edge after its inputs: 0 when wfi_i or wfe_i is 1, and 1 when both are 0.
- R9: While quiescent, active_o is registered one edge after its inputs: 1 when wake_i is 1 or wfi_i is 0, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n_i | input | 1 | Asynchronous active-low quiescence request |
| wfi_i | input | 1 | Processor is in WFI standby |
| wfe_i | input | 1 | Processor is in WFE standby |
| wake_i | input | 1 | A wake-up reason is pending |
| accept_n_o | output | 1 | Active-low grant of quiescence |
| deny_o | output | 1 | Active-high refusal of the request |
| active_o | output | 1 | Activity hint to the power controller |

## Verification
Handshakes are run with four standby patterns: WFI alone, WFE alone, no standby, and WFI with a wake-up pending. Only the first of these may be granted, so the set separates the grant condition from the hint condition, which treats both standby states alike. Inside each handshake the status pins are toggled while the request is held, to show that the answer is latched and not re-evaluated. Outputs are sampled on both sides of the synchroniser delay, in both directions, so that a missing or extra stage shows up. While quiescent, the wake-up pin and the WFI pin are each toggled on its own to show the hint switching to its quiescent rule.

// File: rtl/qhs_pkg.sv
package qhs_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_QUIET   = 2'd1,
    ST_REFUSED = 2'd2
  } qhs_state_e;
endpackage

// File: rtl/qhs_sync.sv
module qhs_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RESET_VAL;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RESET_VAL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/qhs_fsm.sv
module qhs_fsm
  import qhs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_s_n,
  input  logic       grant_ok,
  output qhs_state_e state_o,
  output logic       accept_n_o,
  output logic       deny_o
);
  qhs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (!req_s_n) state_d = grant_ok ? ST_QUIET : ST_REFUSED;
      end
      ST_QUIET, ST_REFUSED: begin
        if (req_s_n) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign state_o    = state_q;
  assign accept_n_o = (state_q != ST_QUIET);
  assign deny_o     = (state_q == ST_REFUSED);
endmodule

// File: rtl/qhs_hint.sv
module qhs_hint (
  input  logic clk,
  input  logic rst_n,
  input  logic quiet_i,
  input  logic wfi_i,
  input  logic wfe_i,
  input  logic wake_i,
  output logic active_o
);
  logic hint_d, hint_q;

  always_comb begin
    if (quiet_i) hint_d = wake_i | ~wfi_i;
    else         hint_d = ~(wfi_i | wfe_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hint_q <= 1'b1;
    else        hint_q <= hint_d;
  end

  assign active_o = hint_q;
endmodule

// File: rtl/qhs_responder.sv
module qhs_responder
  import qhs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_i,
  input  logic wfi_i,
  input  logic wfe_i,
  input  logic wake_i,
  output logic accept_n_o,
  output logic deny_o,
  output logic active_o
);
  logic       req_sync;
  logic       grant_ok;
  qhs_state_e state;

  qhs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (req_n_i),
    .q_o   (req_sync)
  );

  assign grant_ok = wfi_i & ~wake_i;

  qhs_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_s_n    (req_sync),
    .grant_ok   (grant_ok),
    .state_o    (state),
    .accept_n_o (accept_n_o),
    .deny_o     (deny_o)
  );

  qhs_hint u_hint (
    .clk      (clk),
    .rst_n    (rst_n),
    .quiet_i  (state == ST_QUIET),
    .wfi_i    (wfi_i),
    .wfe_i    (wfe_i),
    .wake_i   (wake_i),
    .active_o (active_o)
  );
endmodule

// File: rtl/qhs_responder_chk.sv
module qhs_responder_chk (
  input logic clk,
  input logic rst_n,
  input logic req_s,
  input logic wfi_i,
  input logic wake_i,
  input logic accept_n_o,
  input logic deny_o
);
  a_r7_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(!accept_n_o && deny_o));

  a_r3_grant_needs_wfi: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(accept_n_o) |-> $past(wfi_i && !wake_i));

  a_r4_refuse_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deny_o) |-> $past(accept_n_o) && !$past(wfi_i && !wake_i));

  a_r5_accept_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_n_o && !req_s) |=> !accept_n_o);

  a_r5_deny_held: assert property (@(posedge clk) disable iff (!rst_n)
    (deny_o && !req_s) |=> deny_o);

  a_r6_accept_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_n_o && req_s) |=> accept_n_o);

  a_r6_deny_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (deny_o && req_s) |=> !deny_o);
endmodule

bind qhs_responder qhs_responder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_s      (req_sync),
  .wfi_i      (wfi_i),
  .wake_i     (wake_i),
  .accept_n_o (accept_n_o),
  .deny_o     (deny_o)
);

// File: tb/qhs_responder_test.sv
module qhs_responder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_n = 1'b1, wfi = 1'b0, wfe = 1'b0, wake = 1'b0;
  logic accept_n, deny, active;
  int total = 0, bad = 0;
  logic [1:0] expq[$];
  logic [1:0] prev = 2'b10;
  bit running = 1'b0;

  always #2 clk = ~clk;

  qhs_responder uut (
    .clk(clk), .rst_n(rst_n), .req_n_i(req_n), .wfi_i(wfi), .wfe_i(wfe),
    .wake_i(wake), .accept_n_o(accept_n), .deny_o(deny), .active_o(active)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: every output change is popped from the scoreboard queue
  always @(negedge clk) begin
    if (running) begin
      check(!(!accept_n && deny), "R7 both asserted", {accept_n, deny}, 2'b10);
      if ({accept_n, deny} != prev) begin
        if (expq.size() == 0)
          check(1'b0, "R5 unexpected change", {accept_n, deny}, prev);
        else begin
          logic [1:0] e;
          e = expq.pop_front();
          check({accept_n, deny} == e, "R3/R4/R6 answer", {accept_n, deny}, e);
        end
        prev = {accept_n, deny};
      end
    end
  end

  // driver: one full handshake, expected answer {accept_n,deny} pushed
  task automatic handshake(input logic w_i, input logic w_e, input logic wk,
                           input logic [1:0] ans, input bit quiet_probe);
    wfi = w_i; wfe = w_e; wake = wk;
    cycles(2);
    check(active == ~(w_i | w_e), "R8 hint outside quiescence", active, ~(w_i | w_e));
    expq.push_back(ans);
    expq.push_back(2'b10);
    req_n = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check({accept_n, deny} == 2'b10, "R2 no answer before third edge", {accept_n, deny}, 2'b10);
    @(negedge clk);
    check({accept_n, deny} == ans, "R2 answer on third edge", {accept_n, deny}, ans);
    if (quiet_probe) begin
      @(negedge clk);
      check(active == 1'b0, "R9 hint low while quiet in WFI", active, 0);
      wake = 1'b1; @(negedge clk);
      check(active == 1'b1, "R9 hint high on wake", active, 1);
      wake = 1'b0; @(negedge clk);
      check(active == 1'b0, "R9 hint low again", active, 0);
      wfi = 1'b0; @(negedge clk);
      check(active == 1'b1, "R9 hint high when WFI left", active, 1);
    end
    // R5: toggle status while request held
    wfi = ~w_i; wfe = ~w_e; wake = ~wk; cycles(3);
    wfi = w_i; wfe = w_e; wake = wk; cycles(3);
    check({accept_n, deny} == ans, "R5 answer held", {accept_n, deny}, ans);
    req_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check({accept_n, deny} == ans, "R6 answer kept two edges", {accept_n, deny}, ans);
    @(negedge clk);
    check({accept_n, deny} == 2'b10, "R6 answer dropped", {accept_n, deny}, 2'b10);
    cycles(3);
  endtask

  initial begin
    #800000;
    check(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cycles(3);
    check({accept_n, deny, active} == 3'b101, "R1 reset values", {accept_n, deny, active}, 3'b101);
    rst_n = 1'b1;
    cycles(2);
    check({accept_n, deny, active} == 3'b101, "R1 idle after reset", {accept_n, deny, active}, 3'b101);
    running = 1'b1;
    handshake(1'b1, 1'b0, 1'b0, 2'b00, 1'b1); // R3 WFI grant
    handshake(1'b0, 1'b1, 1'b0, 2'b11, 1'b0); // R4 WFE only refused
    handshake(1'b0, 1'b0, 1'b0, 2'b11, 1'b0); // R4 no standby refused
    handshake(1'b1, 1'b0, 1'b1, 2'b11, 1'b0); // R4 WFI with wake refused
    handshake(1'b1, 1'b1, 1'b0, 2'b00, 1'b0); // R3 grant again after refusals
    cycles(2);
    check(expq.size() == 0, "R6 all answers seen", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule